// File: doc/BRIEF.md
# USB Core Reset and FIFO Flush Sequencer

This block holds the reset-control register of a USB core at offset 0x010 on a simple register bus. Software requests one of four actions by writing a 1 to its action bit. The actions are a full core soft reset, a bus-clock-domain soft reset, a host frame counter reset, and a receive or transmit FIFO flush. An action bit reads back 1 while its action runs. Hardware clears the bit when the action is done. Writing 0 to an action bit never cancels anything.

The core soft reset runs in two phases. USB-side traffic is aborted as soon as the request arrives. The block then waits until the bus transfer in flight has finished. Only then does it assert a clear phase of fixed length. In that phase it aborts bus-side traffic, clears the control/status registers of the core, and flushes every FIFO. During the clear phase a keep mask names the configuration fields that must survive: clock gate, PHY clock stop, PHY clock select and device speed select. The FIFO flushes hold their request until the FIFO returns a done handshake. The transmit flush targets the FIFO number held in a 5-bit field, where 0x10 means all FIFOs.

Top module: `usb_rstctl`

## Requirements
- R1: After reset, a read at offset 0x010 returns 0x2000_0000 while `bus_idle` is 1. Bit 29 always mirrors `bus_idle`, bit 3 always reads 0, and a read at any other offset returns 0.
- R2: Writing bit 0 starts a core reset. From the next cycle `usb_abort` is 1 and bit 0 reads 1. While `bus_busy` stays 1, `csr_clear` and `bus_abort` stay 0.
- R3: Once `bus_busy` is 0, the core reset enters a clear phase of exactly CLR_CYC (default 4) cycles. In that phase `csr_clear`, `bus_abort`, `rxf_flush` and `txf_flush` are all 1, `txf_sel` is 0x10 and `csr_keep` equals KEEP_MASK (default 0xF). After the phase, bit 0 and all of those strobes return to 0.
- R4: While a core reset is in progress, register writes are ignored. On entry to the clear phase, every running action is cancelled and the FIFO number field (bits 10:6) is cleared.
- R5: Writing bit 1 drives `hclk_rst` high for HS_CYC (default 2) cycles. Bit 1 reads 1 for exactly those cycles.
- R6: Writing bit 2 while `host_mode` is 1 drives `frm_cnt_rst` high for one cycle, and bit 2 reads 1 for that cycle. While `host_mode` is 0, the same write leaves bit 2 at 0 and `frm_cnt_rst` at 0.
- R7: Writing bit 4 holds `rxf_flush` and bit 4 at 1 for at least RX_HOLD (default 8) cycles. They stay at 1 until a cycle in which `rxf_done` is seen. With `rxf_done` held at 1, the flush lasts exactly RX_HOLD cycles.
- R8: Writing bit 5 holds `txf_flush` at 1 until `txf_done` is seen. `txf_sel` carries the FIFO number written in bits 10:6 of the same write, and 0x10 selects all FIFOs.
- R9: The FIFO number field cannot be changed while a transmit flush runs. Writing 0 to an action bit, or writing the reserved bit 3, has no effect.
- R10: A write that sets bit 0 together with other action bits starts only the core reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational on `reg_addr`) |
| host_mode | input | 1 | Core operates as host |
| bus_busy | input | 1 | A bus transfer is in flight |
| bus_idle | input | 1 | Bus master state machine is idle |
| rxf_done | input | 1 | Receive FIFO flush complete |
| txf_done | input | 1 | Transmit FIFO flush complete |
| usb_abort | output | 1 | Terminate USB-side transactions |
| bus_abort | output | 1 | Return bus slave to idle |
| csr_clear | output | 1 | Clear interrupts and control/status bits |
| csr_keep | output | KEEP_W | Fields exempt from `csr_clear` |
| hclk_rst | output | 1 | Bus-clock-domain soft reset |
| frm_cnt_rst | output | 1 | Host frame counter reset |
| rxf_flush | output | 1 | Receive FIFO flush request |
| txf_flush | output | 1 | Transmit FIFO flush request |
| txf_sel | output | 5 | Transmit FIFO number to flush (0x10 = all) |

## Verification
A table of single writes covers several cases. The frame counter bit is written in host mode and in device mode, which separates the mode gate from the write decode. Zero writes and reserved-bit writes show that nothing starts. Writes to the FIFO number field show that it is a plain storage field, unlike the action bits. Directed sequences compare receive flushes with `rxf_done` held high against flushes with it held low, which shows the minimum hold time apart from the wait for the handshake. A core reset is started while `bus_busy` is high and a transmit flush is running. This exposes the drain phase, the writes ignored in that phase, the exact clear-phase length and the cancellation of the running flush. A final write that combines several action bits with bit 0 checks which request wins.

// File: rtl/usb_rstctl_pkg.sv
package usb_rstctl_pkg;

    // Bit positions of the reset-control register (decoded by software)
    localparam int unsigned B_CS    = 0;
    localparam int unsigned B_HS    = 1;
    localparam int unsigned B_FC    = 2;
    localparam int unsigned B_RX    = 4;
    localparam int unsigned B_TX    = 5;
    localparam int unsigned TXN_LO  = 6;
    localparam int unsigned TXN_W   = 5;
    localparam int unsigned B_IDLE  = 29;

    typedef logic [TXN_W-1:0] txn_t;
    localparam txn_t TXN_ALL = 5'h10;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_DRAIN = 2'd1,
        CS_CLEAR = 2'd2
    } cs_state_t;

    // Decoded write request
    typedef struct packed {
        logic cs;
        logic hs;
        logic fc;
        logic rx;
        logic tx;
        txn_t txn;
    } wr_req_t;

    // Register contents as seen by a read
    typedef struct packed {
        logic idle;
        txn_t txn;
        logic tx;
        logic rx;
        logic fc;
        logic hs;
        logic cs;
    } ctl_view_t;

    function automatic wr_req_t decode_wr(input logic [31:0] d);
        wr_req_t r;
        r.cs  = d[B_CS];
        r.hs  = d[B_HS];
        r.fc  = d[B_FC];
        r.rx  = d[B_RX];
        r.tx  = d[B_TX];
        r.txn = d[TXN_LO +: TXN_W];
        return r;
    endfunction

    function automatic logic [31:0] pack_view(input ctl_view_t v);
        logic [31:0] r;
        r                  = '0;
        r[B_CS]            = v.cs;
        r[B_HS]            = v.hs;
        r[B_FC]            = v.fc;
        r[B_RX]            = v.rx;
        r[B_TX]            = v.tx;
        r[TXN_LO +: TXN_W] = v.txn;
        r[B_IDLE]          = v.idle;
        return r;
    endfunction

endpackage

// File: rtl/rstctl_hold_req.sv
// Set-by-start request that stays busy for at least MIN_CYC cycles and
// until a done handshake is seen; kill drops it at once.
module rstctl_hold_req #(
    parameter int unsigned MIN_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic kill,
    input  logic done,
    output logic busy
);
    localparam int unsigned CW   = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end else if (cnt == LAST) begin
            if (done) busy <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rstctl_core_seq.sv
// Core soft reset: drain until the bus transfer ends, then a clear phase.
module rstctl_core_seq
    import usb_rstctl_pkg::*;
#(
    parameter int unsigned CLR_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic bus_busy,
    output logic active,
    output logic clearing,
    output logic enter_clear
);
    localparam int unsigned CW   = (CLR_CYC > 1) ? $clog2(CLR_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLR_CYC - 1);

    cs_state_t     state;
    logic [CW-1:0] cnt;

    assign active      = (state != CS_IDLE);
    assign clearing    = (state == CS_CLEAR);
    assign enter_clear = (state == CS_DRAIN) && !bus_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CS_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                CS_IDLE:  if (start) state <= CS_DRAIN;
                CS_DRAIN: if (!bus_busy) begin
                    state <= CS_CLEAR;
                    cnt   <= '0;
                end
                CS_CLEAR: begin
                    if (cnt == LAST) state <= CS_IDLE;
                    else             cnt   <= cnt + 1'b1;
                end
                default:  state <= CS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/usb_rstctl.sv
module usb_rstctl
    import usb_rstctl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h10,
    parameter int unsigned CLR_CYC   = 4,
    parameter int unsigned HS_CYC    = 2,
    parameter int unsigned RX_HOLD   = 8,
    parameter int unsigned KEEP_W    = 4,
    parameter logic [KEEP_W-1:0] KEEP_MASK = 4'hF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              host_mode,
    input  logic              bus_busy,
    input  logic              bus_idle,
    input  logic              rxf_done,
    input  logic              txf_done,
    output logic              usb_abort,
    output logic              bus_abort,
    output logic              csr_clear,
    output logic [KEEP_W-1:0] csr_keep,
    output logic              hclk_rst,
    output logic              frm_cnt_rst,
    output logic              rxf_flush,
    output logic              txf_flush,
    output logic [TXN_W-1:0]  txf_sel
);
    wr_req_t   req;
    logic      wr_hit, wr_sub;
    logic      cs_active, cs_clear, cs_enter;
    logic      hs_busy, rx_busy, tx_busy;
    logic      fc_q;
    txn_t      txn_q;
    ctl_view_t view;

    assign req    = decode_wr(reg_wdata);
    // writes are dropped for the whole core reset
    assign wr_hit = reg_wr && (reg_addr == REG_OFS) && !cs_active;
    // core reset wins over any other action in the same write
    assign wr_sub = wr_hit && !req.cs;

    rstctl_core_seq #(.CLR_CYC(CLR_CYC)) u_core (
        .clk(clk), .rst(rst), .start(wr_hit && req.cs), .bus_busy(bus_busy),
        .active(cs_active), .clearing(cs_clear), .enter_clear(cs_enter)
    );

    rstctl_hold_req #(.MIN_CYC(HS_CYC)) u_hs (
        .clk(clk), .rst(rst), .start(wr_sub && req.hs), .kill(cs_enter),
        .done(1'b1), .busy(hs_busy)
    );

    rstctl_hold_req #(.MIN_CYC(RX_HOLD)) u_rx (
        .clk(clk), .rst(rst), .start(wr_sub && req.rx), .kill(cs_enter),
        .done(rxf_done), .busy(rx_busy)
    );

    rstctl_hold_req #(.MIN_CYC(1)) u_tx (
        .clk(clk), .rst(rst), .start(wr_sub && req.tx), .kill(cs_enter),
        .done(txf_done), .busy(tx_busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fc_q  <= 1'b0;
            txn_q <= '0;
        end else begin
            fc_q <= wr_sub && req.fc && host_mode;
            if (cs_enter)
                txn_q <= '0;
            else if (wr_sub && !tx_busy)
                txn_q <= req.txn;
        end
    end

    always_comb begin
        view.idle = bus_idle;
        view.txn  = txn_q;
        view.tx   = tx_busy;
        view.rx   = rx_busy;
        view.fc   = fc_q;
        view.hs   = hs_busy;
        view.cs   = cs_active;
    end

    assign reg_rdata   = (reg_addr == REG_OFS) ? pack_view(view) : 32'h0;
    assign usb_abort   = cs_active;
    assign bus_abort   = cs_clear;
    assign csr_clear   = cs_clear;
    assign csr_keep    = cs_clear ? KEEP_MASK : '0;
    assign hclk_rst    = hs_busy;
    assign frm_cnt_rst = fc_q;
    assign rxf_flush   = rx_busy || cs_clear;
    assign txf_flush   = tx_busy || cs_clear;
    assign txf_sel     = cs_clear ? TXN_ALL : txn_q;
endmodule

// File: rtl/usb_rstctl_chk.sv
module rstctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       host_mode,
    input logic       bus_busy,
    input logic       rxf_done,
    input logic       txf_done,
    input logic       usb_abort,
    input logic       csr_clear,
    input logic       hclk_rst,
    input logic       frm_cnt_rst,
    input logic       rxf_flush,
    input logic       txf_flush,
    input logic [4:0] txf_sel
);
    assert_drain_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (usb_abort && !csr_clear && bus_busy) |=> (usb_abort && !csr_clear));

    assert_clear_all_fifos_R3: assert property (@(posedge clk) disable iff (rst)
        csr_clear |-> (txf_flush && rxf_flush && txf_sel == 5'h10));

    assert_clear_ends_reset_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(csr_clear) |-> !usb_abort);

    assert_hclk_not_in_clear_R4: assert property (@(posedge clk) disable iff (rst)
        hclk_rst |-> !csr_clear);

    assert_frame_host_only_R6: assert property (@(posedge clk) disable iff (rst)
        frm_cnt_rst |-> $past(host_mode));

    assert_rx_waits_done_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(rxf_flush) && !$past(csr_clear)) |-> $past(rxf_done));

    assert_tx_sel_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (txf_flush && !usb_abort && !txf_done) |=> (txf_flush && $stable(txf_sel)));
endmodule

bind usb_rstctl rstctl_chk u_chk (
    .clk(clk), .rst(rst), .host_mode(host_mode), .bus_busy(bus_busy),
    .rxf_done(rxf_done), .txf_done(txf_done), .usb_abort(usb_abort),
    .csr_clear(csr_clear), .hclk_rst(hclk_rst), .frm_cnt_rst(frm_cnt_rst),
    .rxf_flush(rxf_flush), .txf_flush(txf_flush), .txf_sel(txf_sel)
);

// File: tb/sim_usb_rstctl.sv
`timescale 1ns/1ps
module sim_usb_rstctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h10;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        host_mode = 1'b1, bus_busy = 1'b0, bus_idle = 1'b1;
    logic        rxf_done = 1'b0, txf_done = 1'b0;
    logic        usb_abort, bus_abort, csr_clear, hclk_rst, frm_cnt_rst;
    logic        rxf_flush, txf_flush;
    logic [3:0]  csr_keep;
    logic [4:0]  txf_sel;

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 1'b0;

    always #2 clk = ~clk;

    usb_rstctl u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_mode(host_mode),
        .bus_busy(bus_busy), .bus_idle(bus_idle), .rxf_done(rxf_done),
        .txf_done(txf_done), .usb_abort(usb_abort), .bus_abort(bus_abort),
        .csr_clear(csr_clear), .csr_keep(csr_keep), .hclk_rst(hclk_rst),
        .frm_cnt_rst(frm_cnt_rst), .rxf_flush(rxf_flush), .txf_flush(txf_flush),
        .txf_sel(txf_sel)
    );

    // {wdata, host_mode, expected read one cycle later, expected frm_cnt_rst}
    localparam logic [65:0] VEC [7] = '{
        {32'h0000_0004, 1'b1, 32'h2000_0004, 1'b1},  // R6 host mode
        {32'h0000_0004, 1'b0, 32'h2000_0000, 1'b0},  // R6 device mode
        {32'h0000_0000, 1'b1, 32'h2000_0000, 1'b0},  // R9 zero write
        {32'h0000_0008, 1'b1, 32'h2000_0000, 1'b0},  // R9 reserved bit
        {32'h0000_00C0, 1'b1, 32'h2000_00C0, 1'b0},  // R9 field store
        {32'h0000_0000, 1'b0, 32'h2000_0000, 1'b0},  // R9 field back to 0
        {32'h0000_0404, 1'b1, 32'h2000_0404, 1'b1}   // R6 + field 0x10
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state and read decode
        chk("R1 reset value", reg_rdata, 32'h2000_0000);
        chk("R1 strobes idle", {28'h0, usb_abort, hclk_rst, rxf_flush, txf_flush}, 32'h0);
        bus_idle = 1'b0;
        #1 chk("R1 idle flag low", reg_rdata, 32'h0);
        bus_idle = 1'b1;
        reg_addr = 8'h14;
        #1 chk("R1 other offset", reg_rdata, 32'h0);
        reg_addr = 8'h10;
        @(negedge clk);

        // vector table: R6 and R9
        for (int i = 0; i < 7; i++) begin
            host_mode = VEC[i][65-32];
            wr(VEC[i][65:34]);
            chk($sformatf("R6/R9 vec%0d read", i), reg_rdata, VEC[i][32:1]);
            chk($sformatf("R6 vec%0d frm", i), {31'h0, frm_cnt_rst}, {31'h0, VEC[i][0]});
            @(negedge clk);
            chk($sformatf("R6 vec%0d frm drop", i), {31'h0, frm_cnt_rst}, 32'h0);
            @(negedge clk);
        end
        host_mode = 1'b1;
        wr(32'h0);

        // R5 bus-clock-domain reset lasts two cycles
        wr(32'h2);
        chk("R5 cycle1", {reg_rdata[1], 30'h0, hclk_rst}, {1'b1, 30'h0, 1'b1});
        @(negedge clk);
        chk("R5 cycle2", {31'h0, hclk_rst}, 32'h1);
        @(negedge clk);
        chk("R5 done", {reg_rdata[1], 30'h0, hclk_rst}, 32'h0);

        // R7 receive flush, done held high: exactly 8 cycles
        rxf_done = 1'b1;
        wr(32'h10);
        for (int c = 1; c <= 8; c++) begin
            chk($sformatf("R7 hold c%0d", c), {reg_rdata[4], 30'h0, rxf_flush}, {1'b1, 30'h0, 1'b1});
            @(negedge clk);
        end
        chk("R7 end at 9", {reg_rdata[4], 30'h0, rxf_flush}, 32'h0);

        // R7 receive flush waits for done
        rxf_done = 1'b0;
        wr(32'h10);
        repeat (11) @(negedge clk);
        chk("R7 waits done", {31'h0, rxf_flush}, 32'h1);
        rxf_done = 1'b1;
        @(negedge clk);
        chk("R7 released", {31'h0, rxf_flush}, 32'h0);
        rxf_done = 1'b0;

        // R8 transmit flush on FIFO 5, field locked while busy (R9)
        wr(32'h0000_0160);
        chk("R8 sel", {26'h0, txf_flush, txf_sel}, {26'h0, 1'b1, 5'd5});
        wr(32'h0000_0240);
        chk("R9 field locked", reg_rdata, 32'h2000_0160);
        txf_done = 1'b1;
        @(negedge clk);
        chk("R8 done", {31'h0, txf_flush}, 32'h0);
        txf_done = 1'b0;

        // R2/R3/R4 core reset during a running transmit flush
        wr(32'h0000_01E0);
        chk("R8 tx running", {26'h0, txf_flush, txf_sel}, {26'h0, 1'b1, 5'd7});
        bus_busy = 1'b1;
        wr(32'h1);
        chk("R2 read", reg_rdata, 32'h2000_01E1);
        chk("R2 drain", {29'h0, usb_abort, bus_abort, csr_clear}, 32'h4);
        wr(32'h2);
        chk("R4 write ignored", {reg_rdata[1], 30'h0, hclk_rst}, 32'h0);
        @(negedge clk);
        chk("R2 still drain", {29'h0, usb_abort, bus_abort, csr_clear}, 32'h4);
        bus_busy = 1'b0;
        @(negedge clk);
        for (int c = 1; c <= 4; c++) begin
            chk($sformatf("R3 clear c%0d", c),
                {23'h0, csr_keep, bus_abort, rxf_flush, txf_flush, csr_clear, usb_abort},
                {23'h0, 4'hF, 5'b11111});
            chk($sformatf("R3 all sel c%0d", c), {27'h0, txf_sel}, 32'h10);
            @(negedge clk);
        end
        chk("R3 finished", {26'h0, csr_keep, usb_abort, csr_clear}, 32'h0);
        chk("R4 cancelled", reg_rdata, 32'h2000_0000);
        chk("R4 tx dropped", {31'h0, txf_flush}, 32'h0);

        // R10 core reset wins over other bits
        wr(32'h0000_0013);
        chk("R10 read", reg_rdata, 32'h2000_0001);
        chk("R10 no others", {30'h0, hclk_rst, rxf_flush}, 32'h0);
        repeat (6) @(negedge clk);
        chk("R10 after", reg_rdata, 32'h2000_0000);

        summary();
    end
endmodule